// File: doc/BRIEF.md
# Two-Level Lookup Trigger Unit

This block turns a vector of single-bit cell hits into an 8-bit trigger word. It does this with two levels of programmable tables instead of fixed gates. The hit vector is cut into three equal groups. Each group indexes its own first-level table, which returns a short code. The three codes are joined into the index of a final table, and the entry found there is the trigger word. The lookup path is purely combinational, so the trigger word follows the hits within the same cycle.

A 16-bit register bus writes and reads every table entry, a debug pattern register and a small control register. The control register holds an override bit, which puts the pattern register on the trigger output in place of the final table. It also holds a clear command that walks every table address and writes zero. With all entries zero the unit never fires, so clearing is the way to mask it. The full-size build uses 12-bit groups, 5-bit codes and a 15-bit final index. The parameter defaults are smaller (6-bit groups, 3-bit codes, 9-bit final index) so that the memories stay compact.

Top module: `l2lut_trigger`

## Requirements
- R1: Hit bits [GRP_W-1:0] index first-level table 0, bits [2*GRP_W-1:GRP_W] index table 1 and bits [3*GRP_W-1:2*GRP_W] index table 2.
- R2: The final-table index is {code2, code1, code0}, with code0 in the low CODE_W bits. In table mode, trig_word equals the final entry at that index within the same cycle.
- R3: bus_addr[18:16] selects the target: 0, 1 and 2 are the first-level tables, 3 is the final table, 4 is the pattern register and 5 is the control register. The low address bits pick the entry. A write stores the low CODE_W bits of bus_wdata (first-level), the low OUT_W bits (final table or pattern register), or bit 0 = override and bit 1 = clear command (control register).
- R4: A read (bus_sel=1, bus_we=0) updates bus_rdata on the following clock edge. For a table read, bits [7:0] hold the zero-extended entry and bits [15:8] are zero. A pattern-register read returns zero. A control read returns the override bit in bit 0 and the busy flag in bit 1.
- R5: While the override bit is 1, trig_word equals the pattern register regardless of the hits. Clearing the override bit returns the output to the final table.
- R6: Writing the control register with bit 1 set while idle raises clr_busy on the next edge. clr_busy stays high for exactly 2^max(GRP_W, 3*CODE_W) cycles (512 at the defaults). Afterwards every entry of every table reads zero and trig_word is zero in table mode.
- R7: Bus writes to any table are ignored while clr_busy is high.
- R8: Reset clears the override bit, the pattern register and clr_busy. Table contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hits | input | 3*GRP_W | Cell hit vector |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 19 | Region in [18:16], entry offset in [15:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| trig_word | output | OUT_W | Trigger word |
| clr_busy | output | 1 | High while the clear walk runs |

## Verification
A corrupted table entry changes trig_word combinationally, so it shows in the same cycle as soon as a hit pattern reaches that entry. The bench therefore programs entries that each hit pattern can reach only through the intended bit slices, and compares the word immediately. A stuck or miscounted walk pointer shows as a wrong clr_busy length, or as a non-zero word or readback after the walk. A write that slips past the busy gate survives the walk, and this is observed by reading back entries that the walk passed earlier. Override state faults show on the first hit change, because the output must then either hold the pattern or follow the table.

// File: rtl/l2lut_pkg.sv
package l2lut_pkg;
   localparam int NGRP   = 3;
   localparam int BUS_W  = 16;
   localparam int ADDR_W = 19;
   localparam int OFS_W  = 16;
   localparam int BYTE_W = 8;
   localparam int NTBL   = NGRP + 1;

   typedef enum logic [2:0] {
      RG_T0  = 3'd0,
      RG_T1  = 3'd1,
      RG_T2  = 3'd2,
      RG_FIN = 3'd3,
      RG_PAT = 3'd4,
      RG_CTL = 3'd5
   } region_e;

   localparam int CTL_OVR = 0;
   localparam int CTL_CLR = 1;
endpackage

// File: rtl/l2lut_table.sv
module l2lut_table #(
   parameter int AW = 6,
   parameter int DW = 3
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] lk_addr,
   output logic [DW-1:0] lk_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign lk_data = mem[lk_addr];
   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/l2lut_sweep.sv
module l2lut_sweep #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] LAST = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= '0;
      end else if (busy) begin
         if (ptr == LAST) busy <= 1'b0;
         else             ptr  <= ptr + 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         ptr  <= '0;
      end
   end

   // R6: a command accepted while idle starts the walk at entry zero
   p_walk_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy && ptr == '0);

   // R6: the walk cannot end before the last entry
   p_walk_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && ptr != LAST |=> busy && ptr == $past(ptr) + 1'b1);

   // R6: the walk ends right after the last entry
   p_walk_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && ptr == LAST |=> !busy);
endmodule

// File: rtl/l2lut_busif.sv
module l2lut_busif
   import l2lut_pkg::*;
#(
   parameter int OUT_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_we,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [BUS_W-1:0]            bus_wdata,
   output logic [BUS_W-1:0]            bus_rdata,
   input  logic                        busy,
   input  logic [NTBL-1:0][BYTE_W-1:0] tbl_rd,
   output logic [NTBL-1:0]             tbl_we,
   output logic [OUT_W-1:0]            pat,
   output logic                        ovr,
   output logic                        clr_start
);
   region_e rg;
   logic    wr, rd;

   assign rg = region_e'(bus_addr[ADDR_W-1:OFS_W]);
   assign wr = bus_sel && bus_we;
   assign rd = bus_sel && !bus_we;

   for (genvar i = 0; i < NTBL; i++) begin : g_we
      assign tbl_we[i] = wr && !busy && (bus_addr[ADDR_W-1:OFS_W] == 3'(i));
   end

   assign clr_start = wr && (rg == RG_CTL) && bus_wdata[CTL_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat <= '0;
         ovr <= 1'b0;
      end else if (wr) begin
         if (rg == RG_PAT) pat <= bus_wdata[OUT_W-1:0];
         if (rg == RG_CTL) ovr <= bus_wdata[CTL_OVR];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd) begin
         case (rg)
            RG_T0, RG_T1, RG_T2, RG_FIN:
               bus_rdata <= {{(BUS_W-BYTE_W){1'b0}}, tbl_rd[rg[1:0]]};
            RG_CTL:
               bus_rdata <= {{(BUS_W-2){1'b0}}, busy, ovr};
            default:
               bus_rdata <= '0;
         endcase
      end
   end

   // R4: the upper byte of every read is zero
   p_rd_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> bus_rdata[BUS_W-1:BYTE_W] == '0);

   // R7: no table write strobe while the walk runs
   p_no_wr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> tbl_we == '0);
endmodule

// File: rtl/l2lut_trigger.sv
module l2lut_trigger
   import l2lut_pkg::*;
#(
   parameter int GRP_W  = 6,
   parameter int CODE_W = 3,
   parameter int OUT_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NGRP*GRP_W-1:0] hits,
   input  logic                  bus_sel,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   output logic [OUT_W-1:0]      trig_word,
   output logic                  clr_busy
);
   localparam int FIN_AW  = NGRP * CODE_W;
   localparam int WALK_AW = (GRP_W > FIN_AW) ? GRP_W : FIN_AW;

   if (GRP_W < 1 || GRP_W > OFS_W) begin : g_bad_grp
      $error("GRP_W must lie in 1..16");
   end
   if (FIN_AW > OFS_W) begin : g_bad_fin
      $error("3*CODE_W must not exceed 16");
   end
   if (CODE_W < 1 || CODE_W > BYTE_W) begin : g_bad_code
      $error("CODE_W must lie in 1..8");
   end
   if (OUT_W < 1 || OUT_W > BYTE_W) begin : g_bad_out
      $error("OUT_W must lie in 1..8");
   end

   logic [WALK_AW-1:0]            ptr;
   logic                          busy, clr_start, ovr;
   logic [OUT_W-1:0]              pat, fin_lk, fin_rd;
   logic [NGRP-1:0][CODE_W-1:0]   code, l1_rd;
   logic [NTBL-1:0]               tbl_we;
   logic [NTBL-1:0][BYTE_W-1:0]   tbl_rd;
   logic                          unused_bits;

   assign unused_bits = ^{bus_addr[OFS_W-1:0], bus_wdata, ptr};

   l2lut_sweep #(.AW(WALK_AW)) u_sweep (
      .clk   (clk),
      .rst_n (rst_n),
      .start (clr_start),
      .busy  (busy),
      .ptr   (ptr)
   );

   l2lut_busif #(.OUT_W(OUT_W)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .busy      (busy),
      .tbl_rd    (tbl_rd),
      .tbl_we    (tbl_we),
      .pat       (pat),
      .ovr       (ovr),
      .clr_start (clr_start)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_l1
      l2lut_table #(.AW(GRP_W), .DW(CODE_W)) u_tbl (
         .clk     (clk),
         .we      (busy || tbl_we[g]),
         .waddr   (busy ? ptr[GRP_W-1:0] : bus_addr[GRP_W-1:0]),
         .wdata   (busy ? '0 : bus_wdata[CODE_W-1:0]),
         .lk_addr (hits[g*GRP_W +: GRP_W]),
         .lk_data (code[g]),
         .rd_addr (bus_addr[GRP_W-1:0]),
         .rd_data (l1_rd[g])
      );
      assign tbl_rd[g] = BYTE_W'(l1_rd[g]);
   end

   l2lut_table #(.AW(FIN_AW), .DW(OUT_W)) u_fin (
      .clk     (clk),
      .we      (busy || tbl_we[NGRP]),
      .waddr   (busy ? ptr[FIN_AW-1:0] : bus_addr[FIN_AW-1:0]),
      .wdata   (busy ? '0 : bus_wdata[OUT_W-1:0]),
      .lk_addr (code),
      .lk_data (fin_lk),
      .rd_addr (bus_addr[FIN_AW-1:0]),
      .rd_data (fin_rd)
   );
   assign tbl_rd[NGRP] = BYTE_W'(fin_rd);

   assign trig_word = ovr ? pat : fin_lk;
   assign clr_busy  = busy;

   // R6: once the walk finishes the table path yields no trigger
   p_clear_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && !ovr |-> trig_word == '0);

   // R5: in override mode the output ignores the hits
   p_ovr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && $past(ovr) && $stable(pat) |-> $stable(trig_word));
endmodule

// File: tb/l2lut_trigger_test.sv
module l2lut_trigger_test;
   localparam int GRP_W  = 6;
   localparam int CODE_W = 3;
   localparam int WALK   = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [17:0] hits = '0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [18:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  trig_word;
   logic        clr_busy;

   int errors = 0;
   int checks = 0;
   logic rd_fire = 1'b0;
   logic [15:0] q_exp[$];
   string       q_tag[$];

   always #2 clk = ~clk;

   l2lut_trigger uut (
      .clk(clk), .rst_n(rst_n), .hits(hits),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .trig_word(trig_word), .clr_busy(clr_busy)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [18:0] ad(int rg, int ofs);
      return {3'(rg), 16'(ofs)};
   endfunction

   task automatic wr(logic [18:0] a, logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [18:0] a, logic [15:0] exp, string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic tchk(logic [5:0] g2, logic [5:0] g1, logic [5:0] g0,
                       logic [7:0] exp, string tag);
      @(negedge clk);
      hits = {g2, g1, g0};
      #1;
      chk(tag, trig_word, exp);
   endtask

   always @(posedge clk) rd_fire <= bus_sel && !bus_we;

   always @(negedge clk) begin
      if (rd_fire) begin
         if (q_exp.size() == 0) begin
            chk("R4 unexpected read", 1, 0);
         end else begin
            chk(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 busy after reset", clr_busy, 0);
      rd(ad(5, 0), 16'h0000, "R8 ctrl after reset");

      // R6: clear walk length
      wr(ad(5, 0), 16'h0002);
      cnt = 0;
      while (clr_busy && cnt < 10000) begin
         cnt++;
         @(negedge clk);
      end
      chk("R6 walk length", cnt, WALK);
      rd(ad(5, 0), 16'h0000, "R6 busy bit low after walk");
      tchk(6'd5, 6'd42, 6'd63, 8'h00, "R6 masked trig a");
      tchk(6'd0, 6'd0, 6'd0, 8'h00, "R6 masked trig b");
      rd(ad(0, 5), 16'h0000, "R6 table0 zero");
      rd(ad(3, 511), 16'h0000, "R6 final last entry zero");

      // R1 R2: program the cascade
      wr(ad(0, 5), 16'h0003);
      wr(ad(1, 42), 16'h0006);
      wr(ad(2, 63), 16'h0001);
      wr(ad(3, 115), 16'h00A5);
      tchk(6'd63, 6'd42, 6'd5, 8'hA5, "R2 full cascade");
      wr(ad(3, 0), 16'h003C);
      tchk(6'd0, 6'd0, 6'd0, 8'h3C, "R2 all-zero hits");
      wr(ad(3, 3), 16'h0081);
      tchk(6'd0, 6'd0, 6'd5, 8'h81, "R1 group0 slice");
      wr(ad(3, 64), 16'h0042);
      tchk(6'd63, 6'd0, 6'd0, 8'h42, "R1 group2 slice");
      wr(ad(3, 48), 16'h0024);
      tchk(6'd0, 6'd42, 6'd0, 8'h24, "R1 group1 slice");

      // R3 R4: readback
      rd(ad(0, 5), 16'h0003, "R4 read table0");
      rd(ad(1, 42), 16'h0006, "R4 read table1");
      rd(ad(3, 115), 16'h00A5, "R4 read final");
      wr(ad(0, 7), 16'hFFFF);
      rd(ad(0, 7), 16'h0007, "R3 code width truncation");
      wr(ad(3, 9), 16'hBEEF);
      rd(ad(3, 9), 16'h00EF, "R4 high byte zero");

      // R5: override
      wr(ad(4, 0), 16'h005A);
      tchk(6'd63, 6'd42, 6'd5, 8'hA5, "R5 pattern inactive");
      wr(ad(5, 0), 16'h0001);
      tchk(6'd63, 6'd42, 6'd5, 8'h5A, "R5 override a");
      tchk(6'd0, 6'd0, 6'd0, 8'h5A, "R5 override b");
      rd(ad(5, 0), 16'h0001, "R4 ctrl ovr bit");
      rd(ad(4, 0), 16'h0000, "R4 pattern reads zero");
      wr(ad(5, 0), 16'h0000);
      tchk(6'd0, 6'd0, 6'd0, 8'h3C, "R5 override released");

      // R7: writes blocked during walk
      wr(ad(5, 0), 16'h0002);
      chk("R6 busy raised", clr_busy, 1);
      rd(ad(5, 0), 16'h0002, "R4 ctrl busy bit");
      wr(ad(3, 0), 16'h00FF);
      wr(ad(3, 3), 16'h0077);
      while (clr_busy) @(negedge clk);
      rd(ad(3, 0), 16'h0000, "R7 final[0] write ignored");
      rd(ad(3, 3), 16'h0000, "R7 final[3] write ignored");
      tchk(6'd0, 6'd0, 6'd0, 8'h00, "R7 trig after blocked write");

      // R8: reset clears override and pattern, tables survive
      wr(ad(3, 0), 16'h0011);
      wr(ad(4, 0), 16'h005A);
      wr(ad(5, 0), 16'h0001);
      tchk(6'd0, 6'd0, 6'd0, 8'h5A, "R8 pre-reset override");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R8 trig from table after reset", trig_word, 8'h11);
      rd(ad(5, 0), 16'h0000, "R8 ctrl cleared");
      rd(ad(3, 0), 16'h0011, "R8 table kept");
      wr(ad(5, 0), 16'h0001);
      tchk(6'd0, 6'd0, 6'd0, 8'h00, "R8 pattern cleared");

      repeat (3) @(negedge clk);
      chk("R4 read queue drained", q_exp.size(), 0);
      finish_run();
   end
endmodule